// File: doc/BRIEF.md
# Register Bank Access Guard

This block checks every general purpose register access a processor makes against a software-programmed protect mask. The register index space from 64 upward is split into banks of sixteen consecutive registers. Each bank has one mask bit. When a program running in User mode names a register in a bank whose mask bit is set, the block flags a protection violation and reports the bank involved. Supervisor code is never restricted, and registers below 64 are never guarded.

An instruction presents up to three register addresses in one cycle: two operands and one result. Each address has its own valid flag. The mode bit arrives with them. The violation flag and the bank index are registered and appear on the cycle after the access, ready for the trap logic to sample. The mask register is loaded by supervisor code. A typical setup guards registers 64 to 95 (banks 0 and 1), which hold system-level data.

Top module: `rbank_guard`

## Requirements
- R1: After reset, `violation` is 0, `violBank` is 0 and the protect mask is all zeros, so no bank is guarded.
- R2: A register index r with 64 <= r <= 255 belongs to bank (r - 64) / 16. Bank k covers registers 64+16k through 79+16k. Banks 0 to 11 exist, so register 95 is in bank 1, register 96 is in bank 2 and register 255 is in bank 11.
- R3: When `userMode` is 0 (Supervisor), no access ever raises `violation`, whatever the mask holds.
- R4: An access to a register below 64 never raises `violation`.
- R5: When `userMode` is 1 and a valid address falls in bank k, and mask bit k is set, `violation` is 1 and `violBank` equals k on the cycle after the access.
- R6: An address whose valid flag is 0 is not checked.
- R7: When several valid addresses hit guarded banks in the same cycle, `violBank` reports the lowest-numbered of those banks.
- R8: The mask loads `protWrData` at a clock edge only when `protWrEn` is 1 and `userMode` is 0. A write attempted while `userMode` is 1 leaves the mask unchanged. A new mask value applies to accesses from the next cycle onward.
- R9: Mask bits 12 to 15 guard no registers. Setting only those bits never raises `violation`.
- R10: When the previous cycle's access raised no violation, `violation` is 0 and `violBank` is 0. A clean access directly after a violating one clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| userMode | input | 1 | 1 = User mode, 0 = Supervisor mode |
| srcAAddr | input | 8 | First operand register index |
| srcAValid | input | 1 | First operand address is in use |
| srcBAddr | input | 8 | Second operand register index |
| srcBValid | input | 1 | Second operand address is in use |
| dstAddr | input | 8 | Result register index |
| dstValid | input | 1 | Result address is in use |
| protWrEn | input | 1 | Request to load the protect mask |
| protWrData | input | 16 | New protect mask, bit k guards bank k |
| violation | output | 1 | Registered protection violation flag |
| violBank | output | 4 | Lowest violating bank, 0 when there is no violation |

## Verification
Both results for an access are due exactly one clock edge after the cycle in which the access is driven. A mask write is treated the same way: it affects only accesses driven in later cycles. The driver stamps each expected item with the cycle count at which it falls due. The monitor samples on the falling edge and compares only the item whose due count matches the current cycle, so a result that arrives one cycle early or late is reported as a failure. Every cycle, including clean ones, carries an expectation, so a flag that lingers is caught as well as one that is missing.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

  // number of register addresses checked per cycle: two operands, one result
  localparam int NUM_PORTS = 3;

  // strobes passed from control to datapath
  typedef struct packed {
    logic protLoad;   // capture a new protect mask this edge
    logic chkEnable;  // accesses this cycle are subject to checking
  } strobes_t;

endpackage

// File: rtl/rbg_ctrl.sv
module rbg_ctrl (
  input  logic              userMode,
  input  logic              protWrEn,
  output rbg_pkg::strobes_t strobes
);

  // Only privileged code may change the mask; only User code is checked.
  always_comb begin
    strobes.protLoad  = protWrEn & ~userMode;
    strobes.chkEnable = userMode;
  end

endmodule

// File: rtl/rbg_bank_decode.sv
module rbg_bank_decode #(
  parameter int ADDR_W     = 8,
  parameter int REG_BASE   = 64,
  parameter int BANK_SHIFT = 4,
  parameter int PROT_W     = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  output logic [PROT_W-1:0] bankHot
);

  localparam int BANK_SIZE = 1 << BANK_SHIFT;
  localparam int NUM_BANKS = ((1 << ADDR_W) - REG_BASE) / BANK_SIZE;

  // one comparator pair per bank; banks that cannot exist stay zero
  for (genvar k = 0; k < PROT_W; k++) begin : g_bank
    if (k < NUM_BANKS) begin : g_live
      localparam int LO = REG_BASE + k * BANK_SIZE;
      localparam int HI = LO + BANK_SIZE - 1;
      assign bankHot[k] = valid
                          && (addr >= ADDR_W'(LO))
                          && (addr <= ADDR_W'(HI));
    end else begin : g_none
      assign bankHot[k] = 1'b0;
    end
  end

endmodule

// File: rtl/rbg_datapath.sv
module rbg_datapath #(
  parameter int ADDR_W     = 8,
  parameter int REG_BASE   = 64,
  parameter int BANK_SHIFT = 4,
  parameter int PROT_W     = 16,
  localparam int IDX_W     = $clog2(PROT_W)
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  rbg_pkg::strobes_t                       strobes,
  input  logic [rbg_pkg::NUM_PORTS-1:0][ADDR_W-1:0] addrs,
  input  logic [rbg_pkg::NUM_PORTS-1:0]           valids,
  input  logic [PROT_W-1:0]                       protWrData,
  output logic                                    violation,
  output logic [IDX_W-1:0]                        violBank
);

  localparam int NP        = rbg_pkg::NUM_PORTS;
  localparam int NUM_BANKS = ((1 << ADDR_W) - REG_BASE) >> BANK_SHIFT;

  logic [PROT_W-1:0]         protReg;
  logic [NP-1:0][PROT_W-1:0] portHot;
  logic [PROT_W-1:0]         anyHot;
  logic [PROT_W-1:0]         guardedHot;
  logic [IDX_W-1:0]          firstIdx;
  logic                      found;

  // protect mask register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 protReg <= '0;
    else if (strobes.protLoad) protReg <= protWrData;
  end

  // per-port bank decode
  for (genvar p = 0; p < NP; p++) begin : g_port
    rbg_bank_decode #(
      .ADDR_W    (ADDR_W),
      .REG_BASE  (REG_BASE),
      .BANK_SHIFT(BANK_SHIFT),
      .PROT_W    (PROT_W)
    ) u_dec (
      .addr   (addrs[p]),
      .valid  (valids[p]),
      .bankHot(portHot[p])
    );
  end

  always_comb begin
    anyHot = '0;
    for (int p = 0; p < NP; p++) anyHot |= portHot[p];
    guardedHot = strobes.chkEnable ? (anyHot & protReg) : '0;
  end

  // lowest-numbered guarded bank wins
  always_comb begin
    firstIdx = '0;
    for (int k = PROT_W - 1; k >= 0; k--) begin
      if (guardedHot[k]) firstIdx = IDX_W'(k);
    end
    found = |guardedHot;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      violBank  <= '0;
    end else begin
      violation <= found;
      violBank  <= found ? firstIdx : '0;
    end
  end

  // ---------------- assertions ----------------
  logic lowOnly;
  always_comb begin
    lowOnly = 1'b1;
    for (int p = 0; p < NP; p++) begin
      if (valids[p] && (addrs[p] >= ADDR_W'(REG_BASE))) lowOnly = 1'b0;
    end
  end

  // R3
  a_r3_super_never_flags: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.chkEnable |=> !violation);

  // R4
  a_r4_low_regs_clean: assert property (@(posedge clk) disable iff (!rstN)
    lowOnly |=> !violation);

  // R8
  a_r8_mask_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.protLoad |=> $stable(protReg));

  // R10
  a_r10_quiet_bank_zero: assert property (@(posedge clk) disable iff (!rstN)
    !violation |-> (violBank == '0));

  // R2
  a_r2_bank_exists: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (int'(violBank) < NUM_BANKS));

endmodule

// File: rtl/rbank_guard.sv
module rbank_guard #(
  parameter int ADDR_W     = 8,
  parameter int REG_BASE   = 64,
  parameter int BANK_SHIFT = 4,
  parameter int PROT_W     = 16,
  localparam int IDX_W     = $clog2(PROT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userMode,
  input  logic [ADDR_W-1:0] srcAAddr,
  input  logic              srcAValid,
  input  logic [ADDR_W-1:0] srcBAddr,
  input  logic              srcBValid,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic              dstValid,
  input  logic              protWrEn,
  input  logic [PROT_W-1:0] protWrData,
  output logic              violation,
  output logic [IDX_W-1:0]  violBank
);

  rbg_pkg::strobes_t strobes;
  logic [rbg_pkg::NUM_PORTS-1:0][ADDR_W-1:0] addrs;
  logic [rbg_pkg::NUM_PORTS-1:0]             valids;

  assign addrs  = {dstAddr, srcBAddr, srcAAddr};
  assign valids = {dstValid, srcBValid, srcAValid};

  rbg_ctrl u_ctrl (
    .userMode(userMode),
    .protWrEn(protWrEn),
    .strobes (strobes)
  );

  rbg_datapath #(
    .ADDR_W    (ADDR_W),
    .REG_BASE  (REG_BASE),
    .BANK_SHIFT(BANK_SHIFT),
    .PROT_W    (PROT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrs     (addrs),
    .valids    (valids),
    .protWrData(protWrData),
    .violation (violation),
    .violBank  (violBank)
  );

endmodule

// File: tb/rbank_guard_tb_top.sv
`timescale 1ns/1ps
module rbank_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        userMode = 1'b0;
  logic [7:0]  srcAAddr = '0, srcBAddr = '0, dstAddr = '0;
  logic        srcAValid = 1'b0, srcBValid = 1'b0, dstValid = 1'b0;
  logic        protWrEn = 1'b0;
  logic [15:0] protWrData = '0;
  logic        violation;
  logic [3:0]  violBank;

  always #2.5 clk = ~clk;

  rbank_guard dut_i (
    .clk(clk), .rstN(rstN), .userMode(userMode),
    .srcAAddr(srcAAddr), .srcAValid(srcAValid),
    .srcBAddr(srcBAddr), .srcBValid(srcBValid),
    .dstAddr(dstAddr), .dstValid(dstValid),
    .protWrEn(protWrEn), .protWrData(protWrData),
    .violation(violation), .violBank(violBank)
  );

  typedef struct {
    int        due;
    bit        viol;
    bit [3:0]  bank;
    string     tag;
  } exp_t;

  exp_t        expQ[$];
  int          cycCount = 0;
  int          checks = 0;
  int          failures = 0;
  bit [15:0]   protModel = '0;
  bit          done = 1'b0;

  always @(posedge clk) cycCount <= cycCount + 1;

  // driver: one access per cycle, expected result due one edge later
  task automatic drive(input bit user,
                       input bit [7:0] a, input bit av,
                       input bit [7:0] b, input bit bv,
                       input bit [7:0] d, input bit dv,
                       input bit wr, input bit [15:0] wd,
                       input string tag);
    bit [7:0] ad[3];
    bit       vd[3];
    exp_t     e;
    @(posedge clk); #1;
    userMode = user;
    srcAAddr = a; srcAValid = av;
    srcBAddr = b; srcBValid = bv;
    dstAddr  = d; dstValid  = dv;
    protWrEn = wr; protWrData = wd;
    ad[0] = a; ad[1] = b; ad[2] = d;
    vd[0] = av; vd[1] = bv; vd[2] = dv;
    e.due = cycCount + 1; e.viol = 1'b0; e.bank = 4'd0; e.tag = tag;
    for (int p = 0; p < 3; p++) begin
      if (user && vd[p] && ad[p] >= 8'd64) begin
        int k;
        k = (int'(ad[p]) - 64) / 16;
        if (protModel[k] && (!e.viol || k < int'(e.bank))) begin
          e.viol = 1'b1;
          e.bank = 4'(k);
        end
      end
    end
    expQ.push_back(e);
    if (wr && !user) protModel = wd;
  endtask

  // monitor: compare each result on the falling edge of its due cycle
  always @(negedge clk) begin
    if (rstN) begin
      while (expQ.size() > 0 && expQ[0].due == cycCount) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (violation !== e.viol || violBank !== e.bank) begin
          failures++;
          $display("FAIL %s: got viol=%0b bank=%0d, expected viol=%0b bank=%0d",
                   e.tag, violation, violBank, e.viol, e.bank);
        end
      end
    end
  end

  initial begin
    #(5ns * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got running, expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (violation !== 1'b0 || violBank !== 4'd0) begin
      failures++;
      $display("FAIL R1 reset outputs: got viol=%0b bank=%0d, expected 0 0", violation, violBank);
    end
    @(posedge clk); #1 rstN = 1'b1;

    drive(1, 8'd64, 1, 0, 0, 0, 0, 0, 0, "R1 mask clear after reset");
    drive(0, 8'd70, 1, 0, 0, 0, 0, 1, 16'h0003, "R3 supervisor write cycle");
    drive(1, 8'd64, 1, 0, 0, 0, 0, 0, 0, "R5 bank0 guarded");
    drive(1, 0, 0, 0, 0, 8'd95, 1, 0, 0, "R2 reg95 in bank1");
    drive(1, 0, 0, 8'd96, 1, 0, 0, 0, 0, "R2 reg96 in bank2 free");
    drive(1, 8'd63, 1, 8'd10, 1, 8'd0, 1, 0, 0, "R4 low registers");
    drive(0, 8'd70, 1, 8'd90, 1, 8'd80, 1, 0, 0, "R3 supervisor unrestricted");
    drive(1, 8'd70, 0, 8'd90, 0, 8'd80, 0, 0, 0, "R6 invalid ports ignored");
    drive(1, 8'd66, 1, 0, 0, 0, 0, 0, 0, "R10 violation before clear");
    drive(1, 8'd5, 1, 0, 0, 0, 0, 0, 0, "R10 clean access clears flag");
    drive(1, 8'd10, 1, 0, 0, 0, 0, 1, 16'hFFFF, "R8 user write attempt");
    drive(1, 8'd200, 1, 0, 0, 0, 0, 0, 0, "R8 user write ignored");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 16'h0802, "R8 supervisor load");
    drive(1, 8'd255, 1, 0, 0, 0, 0, 0, 0, "R2 reg255 in bank11");
    drive(1, 8'd64, 1, 0, 0, 0, 0, 0, 0, "R8 new mask frees bank0");
    drive(1, 8'd255, 1, 8'd80, 1, 8'd70, 1, 0, 0, "R7 lowest bank wins");
    drive(1, 8'd240, 1, 0, 0, 8'd90, 1, 0, 0, "R7 dst lower than srcA");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 16'hF000, "R9 load upper bits only");
    drive(1, 8'd255, 1, 8'd64, 1, 8'd130, 1, 0, 0, "R9 upper bits guard nothing");
    drive(0, 0, 0, 0, 0, 0, 0, 1, 16'h0FFF, "R8 load all live banks");
    drive(1, 8'd63, 1, 0, 0, 8'd63, 1, 0, 0, "R4 reg63 below base");
    drive(1, 8'd79, 1, 0, 0, 0, 0, 0, 0, "R5 reg79 bank0");
    drive(1, 0, 0, 8'd176, 1, 0, 0, 0, 0, "R5 reg176 bank7");

    @(posedge clk); #1;
    userMode = 1'b0; srcAValid = 1'b0; srcBValid = 1'b0; dstValid = 1'b0; protWrEn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R5 pending results: got %0d left, expected 0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule